// File: doc/BRIEF.md
# Banked Register Address Pointer

This block holds the register pointer of a two-port, 16-bit GPIO expander and decodes it into a register of the file behind it. A host first sends a register-address byte, which loads the pointer. After that, every completed data byte may move the pointer to the next register. The register file itself is outside the block. It uses the port select, the register index and the hit flag to steer each byte. A byte aimed at an address that does not decode reads as zero, and writes to it are dropped.

Two control inputs shape the behaviour. The bank bit chooses how the two ports are laid out in the address space. When it is set, each port has its own bank: port B starts sixteen addresses above port A. When it is clear, the two ports are interleaved: the port A copy of each register is at an even address and its port B partner is at the odd address just above it. The sequential-off bit turns auto-increment off. In the split layout the pointer then stays on one address. In the interleaved layout it swaps between the two registers of a pair.

Each port has eleven registers, at indices 0 to 10 in this order: direction, input polarity, change-interrupt enable, compare value, interrupt control, configuration, pull-up, interrupt flag, interrupt capture, port level, output latch. The configuration register (index 5) is a single register shared by both ports.

Top module: `gpx_addr_ptr`

## Requirements
- R1: After reset, cur_addr is 00h.
- R2: When addr_load is high at a clock edge, cur_addr equals addr_in after that edge. A byte_done strobe in the same cycle is ignored.
- R3: With neither addr_load nor byte_done high, cur_addr keeps its value.
- R4: With bank_sep=1, addresses 00h to 0Ah decode as port_b=0 with reg_idx equal to the address. Addresses 10h to 1Ah decode as port_b=1 with reg_idx equal to the address minus 10h. In both cases addr_hit=1.
- R5: With bank_sep=0, addresses 00h to 15h decode with addr_hit=1, port_b equal to address bit 0, and reg_idx equal to the address shifted right by one.
- R6: Addresses that do not decode give addr_hit=0, port_b=0, reg_idx=0 and cfg_hit=0. With bank_sep=1 these are 0Bh to 0Fh and anything above 1Ah. With bank_sep=0 these are anything above 15h.
- R7: With bank_sep=1 and seq_off=0, byte_done moves the pointer up by one, except that 0Ah goes to 10h and any address at or above 1Ah goes to 00h.
- R8: With bank_sep=0 and seq_off=0, byte_done moves the pointer up by one, and any address at or above 15h goes to 00h.
- R9: With bank_sep=1 and seq_off=1, byte_done leaves the pointer unchanged.
- R10: With bank_sep=0 and seq_off=1, byte_done flips address bit 0, whether the pointer started even or odd.
- R11: cfg_hit is 1 exactly when the pointer decodes to reg_idx 5. That is 05h and 15h with bank_sep=1, and 0Ah and 0Bh with bank_sep=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | A register-address byte has arrived on addr_in |
| addr_in | input | 8 | Start address to load |
| byte_done | input | 1 | One data byte has been transferred |
| bank_sep | input | 1 | 1: split port banks, 0: interleaved pairs |
| seq_off | input | 1 | 1: auto-increment off |
| cur_addr | output | 8 | Current pointer |
| port_b | output | 1 | Decoded register belongs to port B |
| reg_idx | output | 4 | Register index within the port |
| addr_hit | output | 1 | Pointer decodes to a register |
| cfg_hit | output | 1 | Pointer decodes to the shared configuration register |

## Verification
The pointer register is the block's only state, and it appears directly on cur_addr. A wrong pointer therefore shows up at the ports one cycle after the load or strobe that caused it. A wrong decode is purely combinational and shows up in the same cycle. The stimulus runs every wrap point, the 0Ah-to-10h jump, the pair toggle from both even and odd start addresses, the unmapped addresses and the shared configuration addresses, and it compares all five outputs every cycle. Any wrong step is therefore caught on the next byte.

// File: rtl/gpx_ptr_pkg.sv
package gpx_ptr_pkg;
   typedef enum logic [3:0] {
      RK_DIR    = 4'd0,
      RK_POL    = 4'd1,
      RK_IRQEN  = 4'd2,
      RK_CMPVAL = 4'd3,
      RK_IRQCTL = 4'd4,
      RK_CFG    = 4'd5,
      RK_PULL   = 4'd6,
      RK_FLAG   = 4'd7,
      RK_CAPT   = 4'd8,
      RK_PORT   = 4'd9,
      RK_LATCH  = 4'd10
   } reg_kind_e;

   localparam int NUM_REGS   = 11;
   localparam int CFG_INDEX  = int'(RK_CFG);
   localparam int BANK_STEP  = 16;
   localparam int ADDR_BITS  = 8;
endpackage

// File: rtl/gpx_addr_decode.sv
module gpx_addr_decode
   import gpx_ptr_pkg::*;
#(
   parameter int AW      = ADDR_BITS,
   parameter int NREG    = NUM_REGS,
   parameter int BSTRIDE = BANK_STEP,
   parameter int CFG_IDX = CFG_INDEX,
   parameter int IW      = $clog2(NREG)
) (
   input  logic [AW-1:0] addr,
   input  logic          bank_sep,
   output logic          hit,
   output logic          port_b,
   output logic [IW-1:0] idx,
   output logic          cfg
);
   localparam int SW = $clog2(BSTRIDE);
   localparam logic [AW-1:0] A_END  = AW'(NREG);
   localparam logic [AW-1:0] B_BASE = AW'(BSTRIDE);
   localparam logic [AW-1:0] B_END  = AW'(BSTRIDE + NREG);
   localparam logic [AW-1:0] I_END  = AW'(2 * NREG);

   logic [IW-1:0] b_off;

   generate
      if (BSTRIDE == (1 << SW)) begin : g_pow2_bank
         logic [SW-1:0] low_bits;
         assign low_bits = addr[SW-1:0];
         assign b_off    = low_bits[IW-1:0];
      end else begin : g_sub_bank
         logic [AW-1:0] diff;
         assign diff  = addr - B_BASE;
         assign b_off = diff[IW-1:0];
      end
   endgenerate

   always_comb begin
      hit    = 1'b0;
      port_b = 1'b0;
      idx    = '0;
      if (bank_sep) begin
         if (addr < A_END) begin
            hit = 1'b1;
            idx = addr[IW-1:0];
         end else if (addr >= B_BASE && addr < B_END) begin
            hit    = 1'b1;
            port_b = 1'b1;
            idx    = b_off;
         end
      end else if (addr < I_END) begin
         hit    = 1'b1;
         port_b = addr[0];
         idx    = addr[IW:1];
      end
      cfg = hit && (idx == IW'(CFG_IDX));
   end
endmodule

// File: rtl/gpx_addr_step.sv
module gpx_addr_step
   import gpx_ptr_pkg::*;
#(
   parameter int AW      = ADDR_BITS,
   parameter int NREG    = NUM_REGS,
   parameter int BSTRIDE = BANK_STEP
) (
   input  logic [AW-1:0] addr,
   input  logic          bank_sep,
   input  logic          seq_off,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] LAST_A = AW'(NREG - 1);
   localparam logic [AW-1:0] LAST_B = AW'(BSTRIDE + NREG - 1);
   localparam logic [AW-1:0] LAST_I = AW'(2 * NREG - 1);
   localparam logic [AW-1:0] B_BASE = AW'(BSTRIDE);
   localparam logic [AW-1:0] ONE    = AW'(1);

   always_comb begin
      if (bank_sep) begin
         if (seq_off)            nxt = addr;
         else if (addr == LAST_A) nxt = B_BASE;
         else if (addr >= LAST_B) nxt = '0;
         else                     nxt = addr + ONE;
      end else begin
         if (seq_off)             nxt = addr ^ ONE;
         else if (addr >= LAST_I) nxt = '0;
         else                     nxt = addr + ONE;
      end
   end
endmodule

// File: rtl/gpx_addr_ptr.sv
module gpx_addr_ptr
   import gpx_ptr_pkg::*;
#(
   parameter int AW      = ADDR_BITS,
   parameter int NREG    = NUM_REGS,
   parameter int BSTRIDE = BANK_STEP,
   parameter int CFG_IDX = CFG_INDEX,
   parameter int IW      = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr_load,
   input  logic [AW-1:0] addr_in,
   input  logic          byte_done,
   input  logic          bank_sep,
   input  logic          seq_off,
   output logic [AW-1:0] cur_addr,
   output logic          port_b,
   output logic [IW-1:0] reg_idx,
   output logic          addr_hit,
   output logic          cfg_hit
);
   generate
      if (NREG < 2 || NREG > BSTRIDE) begin : g_bad_stride
         $error("bank stride must hold every register of a port");
      end
      if (BSTRIDE + NREG > (1 << AW) || 2 * NREG > (1 << AW)) begin : g_bad_aw
         $error("address width too small for the register map");
      end
      if (IW + 1 > AW || CFG_IDX >= NREG) begin : g_bad_idx
         $error("index width or configuration index out of range");
      end
   endgenerate

   logic [AW-1:0] ptr_q;
   logic [AW-1:0] ptr_nxt;

   gpx_addr_step #(.AW(AW), .NREG(NREG), .BSTRIDE(BSTRIDE)) step_i (
      .addr     (ptr_q),
      .bank_sep (bank_sep),
      .seq_off  (seq_off),
      .nxt      (ptr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q <= '0;
      else if (addr_load) ptr_q <= addr_in;
      else if (byte_done) ptr_q <= ptr_nxt;
   end

   gpx_addr_decode #(.AW(AW), .NREG(NREG), .BSTRIDE(BSTRIDE),
                     .CFG_IDX(CFG_IDX), .IW(IW)) dec_i (
      .addr     (ptr_q),
      .bank_sep (bank_sep),
      .hit      (addr_hit),
      .port_b   (port_b),
      .idx      (reg_idx),
      .cfg      (cfg_hit)
   );

   assign cur_addr = ptr_q;
endmodule

// File: rtl/gpx_addr_ptr_chk.sv
module gpx_addr_ptr_chk
   import gpx_ptr_pkg::*;
#(
   parameter int AW      = ADDR_BITS,
   parameter int NREG    = NUM_REGS,
   parameter int BSTRIDE = BANK_STEP,
   parameter int CFG_IDX = CFG_INDEX,
   parameter int IW      = $clog2(NREG)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          addr_load,
   input logic [AW-1:0] addr_in,
   input logic          byte_done,
   input logic          bank_sep,
   input logic          seq_off,
   input logic [AW-1:0] cur_addr,
   input logic          port_b,
   input logic [IW-1:0] reg_idx,
   input logic          addr_hit,
   input logic          cfg_hit
);
   localparam logic [AW-1:0] LAST_A = AW'(NREG - 1);
   localparam logic [AW-1:0] LAST_I = AW'(2 * NREG - 1);
   localparam logic [AW-1:0] B_BASE = AW'(BSTRIDE);
   localparam logic [AW-1:0] ONE    = AW'(1);

   logic step_en;
   assign step_en = byte_done && !addr_load;

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load |=> cur_addr == $past(addr_in));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_load && !byte_done) |=> $stable(cur_addr));

   assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_hit |-> (reg_idx == '0 && !port_b && !cfg_hit));

   assert_split_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && bank_sep && !seq_off && cur_addr == LAST_A)
      |=> cur_addr == B_BASE);

   assert_pair_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !bank_sep && !seq_off && cur_addr == LAST_I)
      |=> cur_addr == '0);

   assert_split_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && bank_sep && seq_off) |=> $stable(cur_addr));

   assert_pair_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !bank_sep && seq_off)
      |=> cur_addr == ($past(cur_addr) ^ ONE));

   assert_cfg_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |-> (addr_hit && reg_idx == IW'(CFG_IDX)));
endmodule

bind gpx_addr_ptr gpx_addr_ptr_chk #(
   .AW(AW), .NREG(NREG), .BSTRIDE(BSTRIDE), .CFG_IDX(CFG_IDX), .IW(IW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_load (addr_load),
   .addr_in   (addr_in),
   .byte_done (byte_done),
   .bank_sep  (bank_sep),
   .seq_off   (seq_off),
   .cur_addr  (cur_addr),
   .port_b    (port_b),
   .reg_idx   (reg_idx),
   .addr_hit  (addr_hit),
   .cfg_hit   (cfg_hit)
);

// File: tb/gpx_addr_ptr_tb_top.sv
`timescale 1ns/1ps
module gpx_addr_ptr_tb_top;
   typedef struct {
      logic [7:0] addr;
      logic       hit;
      logic       pb;
      logic [3:0] idx;
      logic       cfg;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0;
   logic [7:0] addr_in = 8'h00;
   logic       byte_done = 1'b0;
   logic       bank_sep = 1'b1;
   logic       seq_off = 1'b0;
   logic [7:0] cur_addr;
   logic       port_b;
   logic [3:0] reg_idx;
   logic       addr_hit;
   logic       cfg_hit;

   int checks = 0;
   int errors = 0;
   exp_t exp_q[$];
   logic [7:0] model_ptr = 8'h00;

   always #2 clk = ~clk;

   gpx_addr_ptr dut_i (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .byte_done(byte_done), .bank_sep(bank_sep), .seq_off(seq_off),
      .cur_addr(cur_addr), .port_b(port_b), .reg_idx(reg_idx),
      .addr_hit(addr_hit), .cfg_hit(cfg_hit)
   );

   // expected pointer step, from R7..R10
   function automatic logic [7:0] ref_next(logic [7:0] a, logic split, logic fixed);
      if (split) begin
         if (fixed)         return a;
         if (a == 8'h0A)    return 8'h10;
         if (a >= 8'h1A)    return 8'h00;
         return a + 8'd1;
      end
      if (fixed)            return {a[7:1], ~a[0]};
      if (a >= 8'h15)       return 8'h00;
      return a + 8'd1;
   endfunction

   // expected decode, from R4..R6 and R11
   function automatic exp_t ref_dec(logic [7:0] a, logic split, string tag);
      exp_t e;
      e.addr = a; e.hit = 1'b0; e.pb = 1'b0; e.idx = 4'd0; e.tag = tag;
      if (split) begin
         if (a <= 8'h0A) begin e.hit = 1'b1; e.idx = a[3:0]; end
         else if (a >= 8'h10 && a <= 8'h1A) begin
            e.hit = 1'b1; e.pb = 1'b1; e.idx = 4'(a - 8'h10);
         end
      end else if (a <= 8'h15) begin
         e.hit = 1'b1; e.pb = a[0]; e.idx = a[4:1];
      end
      e.cfg = e.hit && e.idx == 4'd5;
      return e;
   endfunction

   task automatic set_mode(input logic split, input logic fixed);
      @(negedge clk);
      bank_sep = split;
      seq_off  = fixed;
   endtask

   task automatic step(input logic ld, input logic [7:0] a, input logic bd, input string tag);
      @(negedge clk);
      addr_load = ld;
      addr_in   = a;
      byte_done = bd;
      if (ld)      model_ptr = a;
      else if (bd) model_ptr = ref_next(model_ptr, bank_sep, seq_off);
      exp_q.push_back(ref_dec(model_ptr, bank_sep, tag));
   endtask

   task automatic run_bytes(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1, tag);
   endtask

   // monitor: one expected item per clock, sampled after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cur_addr !== e.addr || addr_hit !== e.hit || port_b !== e.pb ||
                reg_idx !== e.idx || cfg_hit !== e.cfg) begin
               errors++;
               $display("FAIL %s: got addr=%h hit=%b pb=%b idx=%0d cfg=%b, expected addr=%h hit=%b pb=%b idx=%0d cfg=%b",
                        e.tag, cur_addr, addr_hit, port_b, reg_idx, cfg_hit,
                        e.addr, e.hit, e.pb, e.idx, e.cfg);
            end
         end
      end
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #10;
      checks++;
      if (cur_addr !== 8'h00) begin
         errors++;
         $display("FAIL R1: got %h expected 00", cur_addr);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R4 R7: split banks, increment, jump across the gap
      set_mode(1'b1, 1'b0);
      step(1'b1, 8'h08, 1'b0, "R2 load");
      run_bytes(5, "R7 split increment / R4 decode");
      step(1'b1, 8'h18, 1'b0, "R2 load");
      run_bytes(4, "R7 split wrap / R4 decode");
      // R6: the gap and above the map
      step(1'b1, 8'h0C, 1'b0, "R6 gap");
      run_bytes(1, "R6 gap step");
      step(1'b1, 8'h1F, 1'b0, "R6 above map");
      run_bytes(1, "R7 wrap from above map");
      // R3 idle
      step(1'b1, 8'h13, 1'b0, "R2 load");
      step(1'b0, 8'h44, 1'b0, "R3 idle");
      step(1'b0, 8'h55, 1'b0, "R3 idle");
      // R2: load wins over byte_done
      step(1'b1, 8'h03, 1'b1, "R2 load priority");
      // R9: fixed address
      set_mode(1'b1, 1'b1);
      step(1'b1, 8'h09, 1'b0, "R2 load");
      run_bytes(3, "R9 split fixed");
      // R11 split: both config addresses
      step(1'b1, 8'h05, 1'b0, "R11 split cfg A");
      step(1'b1, 8'h15, 1'b0, "R11 split cfg B");
      // R5 R8: interleaved increment and wrap
      set_mode(1'b0, 1'b0);
      step(1'b1, 8'h12, 1'b0, "R5 decode");
      run_bytes(5, "R8 pair increment / R5 decode");
      // R6 interleaved above map
      step(1'b1, 8'h16, 1'b0, "R6 interleaved above map");
      run_bytes(1, "R8 wrap from above map");
      // R10: toggle from even and odd starts
      set_mode(1'b0, 1'b1);
      step(1'b1, 8'h12, 1'b0, "R2 load");
      run_bytes(3, "R10 toggle even start");
      step(1'b1, 8'h15, 1'b0, "R2 load");
      run_bytes(2, "R10 toggle odd start");
      // R11 interleaved: config pair
      step(1'b1, 8'h0A, 1'b0, "R11 interleaved cfg A");
      run_bytes(1, "R11 interleaved cfg B");
      // R4 vs R5: same pointer, bank flip decodes differently
      set_mode(1'b1, 1'b1);
      step(1'b0, 8'h00, 1'b0, "R4 decode after bank flip");

      step(1'b0, 8'h00, 1'b0, "R3 idle");
      while (exp_q.size() > 0) @(posedge clk);
      #2;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule